// File: doc/BRIEF.md
# Low-Latency Second-Order IIR Stream Filter

This block is a second-order recursive filter in direct form I. It sits on a sample stream with valid/ready handshakes on both sides. One stream word carries several channels side by side. Every channel runs the same recurrence with the same coefficient set, but each channel keeps its own input and output history. After each sample the block forms and keeps every term of the next output that does not involve the next input. When a new input arrives, only one multiply-add, one rounding and one saturation stand between the input register and the output register.

Coefficients are loaded over a small write port in a separate configuration clock domain, using a strobe, a 3-bit address and a value. Any write to that port stops the filter and clears its history. The filter stays stopped until the commit address is written. The staged set is then copied to the active set as one unit while the data side is still halted, and the filter restarts from a clean state. Samples are never processed with a mix of old and new coefficients.

Top module: `biquad_iir`

## Requirements
- R1: For each channel, output y(n) = round(b0·u(n) + b1·u(n-1) + b2·u(n-2) − a1·y(n-1) − a2·y(n-2)). Coefficients are signed fixed point with COEF_W−2 fraction bits, so the range is −2 to just under +2. The exact sum is rounded half up: add 2^(COEF_W−3), then shift right arithmetically by COEF_W−2. The result is saturated to the signed DATA_W range.
- R2: Channel k occupies bits [k·DATA_W +: DATA_W] of both stream words. Channels share coefficients and never share history.
- R3: A strobe at any address stops the filter. Within a few data-clock cycles, s_ready and m_valid are both low, and all history and precomputed terms are cleared.
- R4: Tap addresses are b0=0, b1=1, b2=2, a1=3, a2=4. Written values only become active after a strobe at address 7. Until that commit arrives, the filter stays stopped however long it waits, and taps that were not rewritten keep their previous values.
- R5: Strobes at addresses 5 and 6 stop the filter like any write but store nothing. After a commit, the active coefficients are unchanged.
- R6: After the configuration reset (sys_rst_n low), the filter is stopped with s_ready and m_valid low until the first commit.
- R7: A sample is taken only on a data-clock edge where s_valid and s_ready are both high. Its result appears on m_data with m_valid high in the next cycle.
- R8: While m_valid is high and m_ready is low:
  - m_data and m_valid hold.
  - s_ready is low.
  - No result is lost or repeated.
- R9: In the cycle after an accepted sample, s_ready is low while the next partial sum is formed.
- R10: After a commit, every channel starts from zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Configuration clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the configuration side; also stops the data side |
| cfg_strobe | input | 1 | Write strobe for the coefficient port |
| cfg_addr | input | 3 | Write address (taps 0 to 4, commit 7) |
| cfg_value | input | COEF_W | Signed coefficient value |
| data_clk | input | 1 | Sample clock |
| s_data | input | DATA_COUNT·DATA_W | Packed input samples |
| s_valid | input | 1 | Input word is valid |
| s_ready | output | 1 | Filter can take an input word |
| m_data | output | DATA_COUNT·DATA_W | Packed filtered samples |
| m_valid | output | 1 | Output word is valid |
| m_ready | input | 1 | Downstream takes the output word |

## Verification
The bench builds the block with DATA_W=16, DATA_COUNT=2 and COEF_W=18 (16 fraction bits). With two channels it can check the field packing and catch any history leaking from one channel into the other. The narrow samples let near-full-scale inputs drive both rails of the saturation. The small widths also let a 64-bit integer model in the bench compute every result exactly. A hand-computed impulse table, whose negative channel lands on rounding ties, pins down the round-half-up rule independently of that model.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  // number of coefficient taps held in the bank
  localparam int NUM_TAPS = 5;
  // tap slots; each slot index equals its write address
  localparam int IDX_B0 = 0;
  localparam int IDX_B1 = 1;
  localparam int IDX_B2 = 2;
  localparam int IDX_A1 = 3;
  localparam int IDX_A2 = 4;
  // the address whose write applies the staged set
  localparam logic [2:0] ADDR_COMMIT = 3'd7;
endpackage

// File: rtl/bq_coef_bank.sv
// Configuration-domain coefficient store: staging, hold flag and delayed copy.
module bq_coef_bank
  import biquad_pkg::*;
#(
  parameter int COEF_W = 25,
  parameter int SETTLE = 4
) (
  input  logic                              sys_clk,
  input  logic                              sys_rst_n,
  input  logic                              cfg_strobe,
  input  logic [2:0]                        cfg_addr,
  input  logic [COEF_W-1:0]                 cfg_value,
  output logic [NUM_TAPS-1:0][COEF_W-1:0]   coef_active,
  output logic                              hold_req
);
  localparam int CNT_W = $clog2(2*SETTLE+1);
  localparam logic [CNT_W-1:0] COPY_AT    = CNT_W'(SETTLE);
  localparam logic [CNT_W-1:0] RELEASE_AT = CNT_W'(2*SETTLE);

  logic [NUM_TAPS-1:0][COEF_W-1:0] staged_q;
  logic [NUM_TAPS-1:0][COEF_W-1:0] active_q;
  logic                            hold_q;
  logic                            pend_q;
  logic [CNT_W-1:0]                cnt_q;

  // named events
  logic wr_commit;
  logic copy_now;
  logic release_now;
  logic [NUM_TAPS-1:0] wr_tap;

  assign wr_commit   = cfg_strobe && (cfg_addr == ADDR_COMMIT);
  assign copy_now    = pend_q && (cnt_q == COPY_AT);
  assign release_now = pend_q && (cnt_q == RELEASE_AT);

  genvar g;
  generate
    for (g = 0; g < NUM_TAPS; g++) begin : g_tap_sel
      assign wr_tap[g] = cfg_strobe && (cfg_addr == 3'(g));
    end
  endgenerate

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      staged_q <= '0;
      active_q <= '0;
      hold_q   <= 1'b1;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      for (int i = 0; i < NUM_TAPS; i++) begin
        if (wr_tap[i]) staged_q[i] <= cfg_value;
      end
      // the active set only moves while the data side has long been halted
      if (copy_now) active_q <= staged_q;
      if (cfg_strobe) begin
        hold_q <= 1'b1;
        pend_q <= wr_commit;
        cnt_q  <= '0;
      end else if (pend_q) begin
        if (release_now) begin
          hold_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign coef_active = active_q;
  assign hold_req    = hold_q;

  // R3
  strobe_holds_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    cfg_strobe |=> hold_q);
  // R4
  active_frozen_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !hold_q |=> $stable(active_q));
  // R4
  release_after_commit_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $fell(hold_q) |-> $past(pend_q));
endmodule

// File: rtl/bq_hold_sync.sv
// Carries the hold request into the data clock; asserted at once by configuration reset.
module bq_hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold_in,
  output logic hold_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], hold_in};
  end

  assign hold_out = sh_q[STAGES-1];
endmodule

// File: rtl/bq_flow.sv
// Handshake control shared by all channels.
module bq_flow (
  input  logic clk,
  input  logic hold,
  input  logic s_valid,
  input  logic m_ready,
  output logic s_ready,
  output logic m_valid,
  output logic accept,
  output logic refresh
);
  logic busy_q;
  logic mv_q;

  // a slot is free when the partial sum is current and the output is empty or leaving
  assign s_ready = !hold && !busy_q && (!mv_q || m_ready);
  assign accept  = s_valid && s_ready;
  assign refresh = busy_q;
  assign m_valid = mv_q;

  always_ff @(posedge clk) begin
    if (hold) begin
      busy_q <= 1'b0;
      mv_q   <= 1'b0;
    end else begin
      busy_q <= accept;
      if (accept)       mv_q <= 1'b1;
      else if (m_ready) mv_q <= 1'b0;
    end
  end

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (hold)
    accept |=> m_valid);
  // R9
  refresh_gap_chk: assert property (@(posedge clk) disable iff (hold)
    accept |=> !s_ready);
  // R8
  stall_keeps_valid_chk: assert property (@(posedge clk) disable iff (hold)
    (m_valid && !m_ready) |=> m_valid);
endmodule

// File: rtl/bq_channel.sv
// One channel: history, precomputed partial sum and the final multiply-add.
module bq_channel
  import biquad_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int COEF_W = 25
) (
  input  logic                            clk,
  input  logic                            hold,
  input  logic                            accept,
  input  logic                            refresh,
  input  logic [NUM_TAPS-1:0][COEF_W-1:0] coef,
  input  logic signed [DATA_W-1:0]        u_in,
  output logic signed [DATA_W-1:0]        y_out
);
  localparam int FRAC  = COEF_W - 2;
  localparam int ACC_W = DATA_W + COEF_W + 3;
  localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] Y_MAX = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] Y_MIN = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  // full-precision product of a sample and a coefficient
  function automatic logic signed [ACC_W-1:0] mul_term(
    input logic signed [DATA_W-1:0] d,
    input logic signed [COEF_W-1:0] c);
    logic signed [ACC_W-1:0] de;
    logic signed [ACC_W-1:0] ce;
    de = ACC_W'(d);
    ce = ACC_W'(c);
    return de * ce;
  endfunction

  // round half up to the sample grid, then clamp to the sample range
  function automatic logic signed [DATA_W-1:0] round_sat(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] r;
    logic signed [DATA_W-1:0] res;
    r = (s + HALF) >>> FRAC;
    if (r > Y_MAX)      res = Y_MAX[DATA_W-1:0];
    else if (r < Y_MIN) res = Y_MIN[DATA_W-1:0];
    else                res = r[DATA_W-1:0];
    return res;
  endfunction

  logic signed [COEF_W-1:0] c_b0, c_b1, c_b2, c_a1, c_a2;
  assign c_b0 = $signed(coef[IDX_B0]);
  assign c_b1 = $signed(coef[IDX_B1]);
  assign c_b2 = $signed(coef[IDX_B2]);
  assign c_a1 = $signed(coef[IDX_A1]);
  assign c_a2 = $signed(coef[IDX_A2]);

  logic signed [DATA_W-1:0] u1_q, u2_q, y1_q, y2_q, yo_q;
  logic signed [ACC_W-1:0]  part_q;
  logic signed [ACC_W-1:0]  acc_now;
  logic signed [ACC_W-1:0]  part_next;
  logic signed [DATA_W-1:0] y_new;

  assign acc_now   = mul_term(u_in, c_b0) + part_q;
  assign y_new     = round_sat(acc_now);
  // terms of the next output known once this sample is in the history
  assign part_next = mul_term(u1_q, c_b1) + mul_term(u2_q, c_b2)
                   - mul_term(y1_q, c_a1) - mul_term(y2_q, c_a2);

  always_ff @(posedge clk) begin
    if (hold) begin
      u1_q   <= '0;
      u2_q   <= '0;
      y1_q   <= '0;
      y2_q   <= '0;
      yo_q   <= '0;
      part_q <= '0;
    end else if (accept) begin
      yo_q <= y_new;
      u1_q <= u_in;
      u2_q <= u1_q;
      y1_q <= y_new;
      y2_q <= y1_q;
    end else if (refresh) begin
      part_q <= part_next;
    end
  end

  assign y_out = yo_q;

  // R10
  hold_clears_chk: assert property (@(posedge clk)
    $past(hold) |-> (part_q == '0 && y1_q == '0 && u1_q == '0));
endmodule

// File: rtl/biquad_iir.sv
// Top: configuration bank, hold crossing, handshake control and per-channel datapaths.
module biquad_iir
  import biquad_pkg::*;
#(
  parameter int DATA_W      = 28,
  parameter int DATA_COUNT  = 1,
  parameter int COEF_W      = 25,
  parameter int SETTLE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         sys_clk,
  input  logic                         sys_rst_n,
  input  logic                         cfg_strobe,
  input  logic [2:0]                   cfg_addr,
  input  logic [COEF_W-1:0]            cfg_value,
  input  logic                         data_clk,
  input  logic [DATA_COUNT*DATA_W-1:0] s_data,
  input  logic                         s_valid,
  output logic                         s_ready,
  output logic [DATA_COUNT*DATA_W-1:0] m_data,
  output logic                         m_valid,
  input  logic                         m_ready
);
  logic [NUM_TAPS-1:0][COEF_W-1:0] coef_active;
  logic hold_req;
  logic hold_d;
  logic accept;
  logic refresh;

  bq_coef_bank #(.COEF_W(COEF_W), .SETTLE(SETTLE)) u_bank (
    .sys_clk     (sys_clk),
    .sys_rst_n   (sys_rst_n),
    .cfg_strobe  (cfg_strobe),
    .cfg_addr    (cfg_addr),
    .cfg_value   (cfg_value),
    .coef_active (coef_active),
    .hold_req    (hold_req)
  );

  bq_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (data_clk),
    .arst_n   (sys_rst_n),
    .hold_in  (hold_req),
    .hold_out (hold_d)
  );

  bq_flow u_flow (
    .clk     (data_clk),
    .hold    (hold_d),
    .s_valid (s_valid),
    .m_ready (m_ready),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .accept  (accept),
    .refresh (refresh)
  );

  genvar g;
  generate
    for (g = 0; g < DATA_COUNT; g++) begin : g_chan
      bq_channel #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chan (
        .clk     (data_clk),
        .hold    (hold_d),
        .accept  (accept),
        .refresh (refresh),
        .coef    (coef_active),
        .u_in    (s_data[g*DATA_W +: DATA_W]),
        .y_out   (m_data[g*DATA_W +: DATA_W])
      );
    end
  endgenerate

  // R8
  stall_data_stable_chk: assert property (@(posedge data_clk) disable iff (hold_d)
    (m_valid && !m_ready) |=> $stable(m_data));
  // R3
  hold_drops_valid_chk: assert property (@(posedge data_clk) disable iff (!sys_rst_n)
    hold_d |=> !m_valid);
endmodule

// File: tb/biquad_iir_tb.sv
`timescale 1ns/1ps
module biquad_iir_tb;
  localparam int DW   = 16;
  localparam int DC   = 2;
  localparam int CW   = 18;
  localparam int FRAC = CW - 2;
  localparam int WW   = DW * DC;
  localparam longint YMAX = (64'sd1 <<< (DW-1)) - 1;
  localparam longint YMIN = -(64'sd1 <<< (DW-1));

  // impulse table: in ch0, in ch1, expected ch0, expected ch1
  // b0=0.5 b1=0.25 b2=0 a1=-0.5 a2=0; ch1 lands on halves and checks rounding toward +inf
  localparam int TBL_N = 8;
  localparam int TBL [0:TBL_N-1][0:3] = '{
    '{1000, -1000, 500, -500},
    '{0,    0,     500, -500},
    '{0,    0,     250, -250},
    '{0,    0,     125, -125},
    '{0,    0,     63,  -62},
    '{0,    0,     32,  -31},
    '{0,    0,     16,  -15},
    '{0,    0,     8,   -7}
  };

  logic sys_clk = 0, data_clk = 0, sys_rst_n = 0, cfg_strobe = 0;
  logic [2:0] cfg_addr = '0;
  logic [CW-1:0] cfg_value = '0;
  logic [WW-1:0] s_data = '0;
  logic s_valid = 0, s_ready;
  logic [WW-1:0] m_data;
  logic m_valid, m_ready = 0;

  always #2.5 data_clk = ~data_clk;
  always #4   sys_clk  = ~sys_clk;

  biquad_iir #(.DATA_W(DW), .DATA_COUNT(DC), .COEF_W(CW)) u_dut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cfg_strobe(cfg_strobe),
    .cfg_addr(cfg_addr), .cfg_value(cfg_value), .data_clk(data_clk),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready));

  int checks = 0, errors = 0;
  longint mc [0:4];
  longint h_u1 [0:DC-1], h_u2 [0:DC-1], h_y1 [0:DC-1], h_y2 [0:DC-1];
  logic [WW-1:0] exp_q [$];
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(posedge data_clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R7: watchdog actual=%0d expected=%0d cycles", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // reference: exact integer sum, floor((s + half) / 2^FRAC), clamp
  function automatic longint ref_round(input longint s);
    longint r;
    r = (s + (64'sd1 <<< (FRAC-1))) >>> FRAC;
    if (r > YMAX) r = YMAX;
    if (r < YMIN) r = YMIN;
    return r;
  endfunction

  function automatic longint model_step(input int ch, input longint u);
    longint s, y;
    s = mc[0]*u + mc[1]*h_u1[ch] + mc[2]*h_u2[ch] - mc[3]*h_y1[ch] - mc[4]*h_y2[ch];
    y = ref_round(s);
    h_u2[ch] = h_u1[ch]; h_u1[ch] = u;
    h_y2[ch] = h_y1[ch]; h_y1[ch] = y;
    return y;
  endfunction

  function automatic void model_clear();
    for (int c = 0; c < DC; c++) begin
      h_u1[c] = 0; h_u2[c] = 0; h_y1[c] = 0; h_y2[c] = 0;
    end
  endfunction

  function automatic longint sample_for(input int mode, input int idx, input int ch);
    longint v;
    case (mode)
      0: v = TBL[idx][ch];
      1: v = (ch == 0) ? 12000 : -7000;
      2: v = longint'($urandom_range(0, 32000)) - 16000;
      default: v = (ch == 0) ? (($urandom_range(0, 1) == 1) ? YMAX : YMIN)
                             : longint'($urandom_range(0, 65535)) - 32768;
    endcase
    return v;
  endfunction

  function automatic logic [WW-1:0] make_word(input int mode, input int idx);
    logic [WW-1:0] w;
    for (int c = 0; c < DC; c++) w[c*DW +: DW] = DW'(sample_for(mode, idx, c));
    return w;
  endfunction

  task automatic cfg_write(input logic [2:0] a, input longint v);
    @(negedge sys_clk);
    cfg_strobe = 1; cfg_addr = a; cfg_value = CW'(v);
    @(negedge sys_clk);
    cfg_strobe = 0;
  endtask

  task automatic wait_release(input string req);
    bit up = 0;
    for (int i = 0; i < 400 && !up; i++) begin
      @(negedge data_clk); #2;
      if (s_ready) up = 1;
    end
    check(up, req, "filter released after commit", longint'(up), 1);
  endtask

  task automatic load_set(input longint b0, input longint b1, input longint b2,
                          input longint a1, input longint a2);
    cfg_write(3'd0, b0); cfg_write(3'd1, b1); cfg_write(3'd2, b2);
    cfg_write(3'd3, a1); cfg_write(3'd4, a2); cfg_write(3'd7, 0);
    mc[0] = b0; mc[1] = b1; mc[2] = b2; mc[3] = a1; mc[4] = a2;
    model_clear();
    wait_release("R4");
  endtask

  task automatic check_halted(input string req, input int wait_cyc);
    repeat (wait_cyc) @(negedge data_clk);
    #2;
    check(!s_ready, req, "s_ready while halted", longint'(s_ready), 0);
    check(!m_valid, req, "m_valid while halted", longint'(m_valid), 0);
  endtask

  // streams n words; bp is the percentage of cycles with m_ready low
  task automatic run_stream(input int mode, input int n, input int bp);
    int sent = 0, got = 0, guard = 0;
    bit prev_acc = 0, prev_stall = 0, acc, outx;
    logic [WW-1:0] prev_m = '0, word, expw, got_w;
    word = make_word(mode, 0);
    while ((sent < n || got < sent) && guard < 20000) begin
      @(negedge data_clk);
      guard++;
      if (prev_acc) s_valid = 0;
      if (!s_valid && sent < n) s_valid = ($urandom_range(0, 99) >= bp/2);
      s_data  = word;
      m_ready = ($urandom_range(0, 99) >= bp);
      #2;
      if (prev_acc) begin
        check(!s_ready, "R9", "s_ready in refresh cycle", longint'(s_ready), 0);
        check(m_valid, "R7", "m_valid after accept", longint'(m_valid), 1);
      end
      if (prev_stall)
        check(m_valid && m_data == prev_m, "R8", "output held during stall",
              longint'(m_data), longint'(prev_m));
      if (m_valid && !m_ready)
        check(!s_ready, "R8", "s_ready during stall", longint'(s_ready), 0);
      acc  = s_valid && s_ready;
      outx = m_valid && m_ready;
      if (outx) begin
        if (exp_q.size() == 0) begin
          check(0, "R8", "unexpected extra output", 1, 0);
        end else begin
          expw  = exp_q.pop_front();
          got_w = m_data;
          for (int c = 0; c < DC; c++)
            check(got_w[c*DW +: DW] == expw[c*DW +: DW], (mode == 0) ? "R2" : "R1",
                  $sformatf("ch%0d output %0d", c, got),
                  longint'($signed(got_w[c*DW +: DW])), longint'($signed(expw[c*DW +: DW])));
        end
        got++;
      end
      if (acc) begin
        for (int c = 0; c < DC; c++) begin
          longint y;
          y = model_step(c, longint'($signed(word[c*DW +: DW])));
          expw[c*DW +: DW] = (mode == 0) ? DW'(TBL[sent][c+2]) : DW'(y);
        end
        exp_q.push_back(expw);
        sent++;
        if (sent < n) word = make_word(mode, sent);
      end
      prev_acc   = acc;
      prev_stall = m_valid && !m_ready;
      prev_m     = m_data;
    end
    @(negedge data_clk);
    s_valid = 0;
    check(guard < 20000, "R8", "stream completed", longint'(got), longint'(n));
  endtask

  initial begin
    mc[0] = 0; mc[1] = 0; mc[2] = 0; mc[3] = 0; mc[4] = 0;
    model_clear();
    repeat (5) @(negedge sys_clk);
    sys_rst_n = 1;
    // R6: stays halted with no commit
    check_halted("R6", 40);

    // R1/R2: hand-computed impulse table, both rounding directions
    load_set(32768, 16384, 0, -32768, 0);
    run_stream(0, TBL_N, 30);

    // R1: stable resonant set, random input with backpressure, then a step
    load_set(13107, 26214, 13107, -72090, 32768);
    run_stream(2, 300, 40);
    run_stream(1, 60, 20);

    // R3: a single tap write halts the running filter
    cfg_write(3'd0, 65536);
    check_halted("R3", 12);
    // R4: no release without the commit
    check_halted("R4", 150);
    cfg_write(3'd7, 0);
    mc[0] = 65536;
    model_clear();
    wait_release("R4");
    // R10: history restarts at zero; untouched taps keep their values
    run_stream(1, 40, 30);

    // R5: unused addresses halt but store nothing
    cfg_write(3'd5, 99999);
    cfg_write(3'd6, -99999);
    check_halted("R5", 12);
    cfg_write(3'd7, 0);
    model_clear();
    wait_release("R5");
    run_stream(2, 100, 50);

    // R1: saturation on both rails
    load_set(130000, 130000, 130000, 0, 0);
    run_stream(3, 80, 30);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule